// File: doc/BRIEF.md
# Serial LED-Driver Word Transmitter

This block sends 16-bit command words to an external serial LED display driver over three wires: a data line, a serial clock and an active-low load strobe. The host presents an 8-bit register address and an 8-bit data byte together with a one-cycle start pulse. The block first sends the address byte and then the data byte, most significant bit first, on a serial clock that it derives from the system clock by a parameterised division ratio.

The transfer moves through an address phase and a data phase. Load is pulled low before the first serial clock pulse. It is returned high on the falling edge that follows the sixteenth rising edge. This is after that edge and well before any further rising edge, so the receiver latches the word. A busy flag tells the host when the next word may be issued. A start pulse that arrives during a transfer is dropped.

Top module: `led_word_tx`

## Requirements
- R1: While idle and after reset, busy is 0, load_n is 1, sclk is 0 and sdo is 0.
- R2: busy rises in the cycle after a start is accepted in idle. It stays 1 until after load_n has returned to 1.
- R3: load_n is 0 before every rising sclk edge of a word, including the first.
- R4: Each word is 16 bits: the address byte goes first, then the data byte, each most significant bit first. The receiver samples sdo on rising sclk edges.
- R5: sdo changes only while sclk is low, so it is stable through every high phase of sclk.
- R6: One sclk period lasts DIV system clock cycles (default 8). The high phase lasts DIV/2 cycles, and sclk idles low between words.
- R7: Exactly 16 rising sclk edges occur while load_n is low. load_n rises after the 16th edge and before any further rising edge.
- R8: A start pulse that arrives while busy is 1 is ignored: the word in flight is unchanged and no extra word follows.
- R9: A start given in the first cycle in which busy reads 0 is accepted, so words can follow each other without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to send a word |
| addr | input | 8 | Register address byte, sent first |
| data | input | 8 | Data byte, sent second |
| busy | output | 1 | A transfer is in progress |
| sclk | output | 1 | Serial clock to the driver |
| load_n | output | 1 | Active-low load / chip-select strobe |
| sdo | output | 1 | Serial data to the driver |

## Verification
The assertions check every cycle that the lines sit quiet when idle and that busy rises only after a start. They also check that load is low ahead of each rising clock edge, that sdo holds still while sclk is high, and that exactly sixteen rising edges fall inside each low period of load. Only the bench scenarios can show that the bits reaching a modelled receiver form the requested address and data. The same applies to the exact period and high time of the serial clock, to a start during a transfer leaving the word intact with no follow-up word, and to back-to-back words starting as soon as busy drops.

// File: rtl/led_word_tx.sv
`timescale 1ns/1ps
module led_word_tx #(
  parameter int DIV    = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              sclk,
  output logic              load_n,
  output logic              sdo
);
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int HALF   = DIV / 2;
  localparam int PH_W   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BIT_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_DONE} state_t;

  state_t            state;
  logic [PH_W-1:0]   ph;
  logic [BIT_W-1:0]  nbit;
  logic [WORD_W-1:0] sreg;
  logic              sclk_q, load_q;

  wire rise_pt  = (ph == PH_W'(HALF - 1));
  wire fall_pt  = (ph == PH_W'(DIV - 1));
  wire addr_end = (nbit == BIT_W'(ADDR_W - 1));
  wire last_bit = (nbit == BIT_W'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ph     <= '0;
      nbit   <= '0;
      sreg   <= '0;
      sclk_q <= 1'b0;
      load_q <= 1'b1;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          sreg   <= {addr, data};
          load_q <= 1'b0;
          ph     <= '0;
          nbit   <= '0;
          state  <= S_ADDR;
        end
        S_ADDR, S_DATA: begin
          ph <= fall_pt ? '0 : ph + 1'b1;
          if (rise_pt) sclk_q <= 1'b1;
          if (fall_pt) begin
            sclk_q <= 1'b0;
            sreg   <= sreg << 1;
            nbit   <= nbit + 1'b1;
            if (state == S_ADDR && addr_end) state <= S_DATA;
            if (last_bit) begin
              load_q <= 1'b1;
              state  <= S_DONE;
            end
          end
        end
        S_DONE: begin
          if (rise_pt) begin
            ph    <= '0;
            state <= S_IDLE;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy   = (state != S_IDLE);
  assign sclk   = sclk_q;
  assign load_n = load_q;
  assign sdo    = sreg[WORD_W-1];
endmodule

module led_word_tx_chk #(
  parameter int WORD_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic sclk,
  input logic load_n,
  input logic sdo
);
  logic       sclk_d;
  logic [5:0] edges;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      edges  <= '0;
    end else begin
      sclk_d <= sclk;
      if (load_n) edges <= '0;
      else if (sclk && !sclk_d) edges <= edges + 1'b1;
    end
  end

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (load_n && !sclk && !sdo));
  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  assert_load_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (!load_n && $past(!load_n)));
  assert_sdo_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdo));
  assert_edge_total_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_n) |-> (edges == 6'(WORD_W)));
  assert_no_extra_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    edges <= 6'(WORD_W));
  assert_load_with_low_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_n) |-> !sclk);
endmodule

bind led_word_tx led_word_tx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .sclk(sclk), .load_n(load_n), .sdo(sdo)
);

// File: tb/led_word_tx_test.sv
`timescale 1ns/1ps
module led_word_tx_test;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;
  localparam int TCK  = 20;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] addr = '0, data = '0;
  logic busy, sclk, load_n, sdo;

  int checks = 0, fails = 0, words_tx = 0, words_rx = 0;
  bit finished = 1'b0;
  logic [15:0] exp_q[$];
  logic [15:0] rx = '0;
  int rcnt = 0;
  bit armed = 1'b0;
  time last_rise = 0;

  always #(TCK/2) clk = ~clk;

  led_word_tx #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .data(data),
    .busy(busy), .sclk(sclk), .load_n(load_n), .sdo(sdo)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_word(input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; addr = a; data = d;
    exp_q.push_back({a, d});
    words_tx++;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, tag, busy, 1);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  always @(negedge load_n) begin
    armed = 1'b1;
    rcnt  = 0;
    rx    = '0;
  end

  always @(posedge sclk) begin
    logic bitv;
    chk(load_n == 1'b0, "R3 load low at rising sclk", load_n, 0);
    if (rcnt >= 16) chk(1'b0, "R7 extra rising edge", rcnt + 1, 16);
    if (rcnt > 0) chk(($time - last_rise) == DIV * TCK, "R6 sclk period",
                      $time - last_rise, DIV * TCK);
    last_rise = $time;
    bitv = sdo;
    rx = {rx[14:0], sdo};
    rcnt++;
    #(HALF * TCK - 10);
    chk(sdo == bitv, "R5 sdo stable while sclk high", sdo, bitv);
  end

  always @(negedge sclk) begin
    if (armed && !$isunknown(last_rise))
      chk(($time - last_rise) == HALF * TCK, "R6 sclk high time",
          $time - last_rise, HALF * TCK);
  end

  always @(posedge load_n) begin
    if (armed) begin
      logic [15:0] e;
      armed = 1'b0;
      words_rx++;
      chk(rcnt == 16, "R7 edges inside load window", rcnt, 16);
      chk(busy == 1'b1, "R2 busy held until load high", busy, 1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected word", rx, 0);
      end else begin
        e = exp_q.pop_front();
        chk(rx == e, "R4 received word", rx, e);
      end
    end
  end

  initial begin
    #(200000 * TCK);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 reset busy", busy, 0);
    chk(load_n == 1, "R1 reset load_n", load_n, 1);
    chk(sclk == 0, "R1 reset sclk", sclk, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(load_n == 1 && sclk == 0 && sdo == 0, "R1 idle lines", {load_n, sclk, sdo}, 3'b100);

    send_word(8'h0F, 8'h01, "R2 busy after start");
    send_word(8'hA5, 8'h5A, "R9 back-to-back start");
    send_word(8'hFF, 8'h00, "R9 back-to-back start");
    send_word(8'h00, 8'hFF, "R9 back-to-back start");
    send_word(8'h80, 8'h01, "R9 back-to-back start");
    send_word(8'h00, 8'h00, "R9 back-to-back start");
    send_word(8'hFF, 8'hFF, "R9 back-to-back start");
    wait_idle();
    repeat (5) @(negedge clk);
    chk(load_n == 1 && sclk == 0 && sdo == 0 && busy == 0, "R1 idle after words",
        {busy, load_n, sclk, sdo}, 4'b0100);

    send_word(8'h0C, 8'h01, "R2 busy after start");
    repeat (40) @(negedge clk);
    start = 1'b1; addr = 8'h33; data = 8'hCC;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1 && load_n == 0, "R8 start during transfer ignored",
        {busy, load_n}, 2'b10);
    wait_idle();
    repeat (4 * DIV) @(negedge clk);
    chk(busy == 0 && load_n == 1, "R8 no follow-up word", {busy, load_n}, 2'b01);

    for (int i = 0; i < 6; i++)
      send_word(8'(i * 37 + 1), 8'(i * 91 + 7), "R9 back-to-back start");
    wait_idle();
    repeat (DIV) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all words delivered", exp_q.size(), 0);
    chk(words_rx == words_tx, "R8 word count", words_rx, words_tx);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule